// File: doc/BRIEF.md
# Lockable Memory Window Decoder

This block keeps two 32-bit configuration registers and decodes incoming addresses against them. One register holds the top of usable memory; the other holds the base of a protected segment that sits just under that top. Software programs both through a single-cycle register port. After that, each address presented with a valid strobe is classified one cycle later. It is claimed as memory when it lies below the top, and flagged as a protected-segment hit when it also lies at or above the segment base.

Both registers keep their programmable value at 1 MB granularity in the upper twelve bits. For comparison the low twenty bits of each register are taken as zero. Bit 0 of each register is a self-locking bit. Once it is written as 1, the register, including that bit, ignores every later write until reset. Firmware normally programs the segment base at or below the graphics base and sets it equal to that base when the segment is not in use. A base at or above the top then yields no segment hits.

Top module: `memwin_decoder`

## Requirements
- R1: After reset the top register reads 0x0010_0000 (field value 1, i.e. 1 MB), the segment base register reads 0x0000_0000, and hit_vld, hit_mem and hit_seg are 0.
- R2: A read returns the 12-bit address field in bits 31:20, zeros in bits 19:1 whatever was written there, and the lock flag in bit 0.
- R3: A write to an unlocked register loads bits 31:20 and bit 0 of cfg_wdata, visible on cfg_rdata from the next cycle.
- R4: While a register's lock bit is 1, writes to that register change neither its field nor its lock bit, and the other register stays writable.
- R5: A set lock bit is cleared only by reset; writing 0 to bit 0 of a locked register leaves it set.
- R6: hit_vld is 1 exactly one cycle after addr_vld was 1; when hit_vld is 0, hit_mem and hit_seg are 0.
- R7: hit_mem is 1 when the strobed 32-bit address is strictly less than the top field shifted left by 20, using the register values of the strobe cycle.
- R8: hit_seg is 1 when the strobed address is at or above the base field shifted left by 20 and below the top value; when base is not below top it is never 1.
- R9: cfg_sel selects the register for reads and writes: 0 is the top register, 1 is the segment base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the selected register |
| cfg_sel | input | 1 | Register select: 0 top, 1 segment base |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| addr_vld | input | 1 | Address valid strobe |
| addr | input | 32 | Address to classify |
| hit_vld | output | 1 | Decode result valid, one cycle after addr_vld |
| hit_mem | output | 1 | Address is below the top of usable memory |
| hit_seg | output | 1 | Address is inside the protected segment |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 20-bit granule and a top reset field of 1. The full 12-bit field range is therefore reachable, so probes can land at the very top of the 4 GB space, one byte under a boundary and exactly on it. Directed steps cover a base above the top, a base equal to the top, locking each register on its own and a reset in the middle of the run. A randomized phase then mixes writes and probes on every cycle against a behavioural model.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  // Register select encoding on the configuration port
  typedef enum logic {
    SEL_TOP  = 1'b0,
    SEL_BASE = 1'b1
  } memwin_sel_e;

  localparam int CMP_W = 64;

  // Address lies under the top of usable memory
  function automatic logic below_top(input logic [CMP_W-1:0] a,
                                     input logic [CMP_W-1:0] top);
    return a < top;
  endfunction

  // Address lies in the protected segment; an empty segment never hits
  function automatic logic in_segment(input logic [CMP_W-1:0] a,
                                      input logic [CMP_W-1:0] base,
                                      input logic [CMP_W-1:0] top);
    return (base < top) && (a >= base) && (a < top);
  endfunction

endpackage

// File: rtl/memwin_lockreg.sv
module memwin_lockreg #(
  parameter int FIELD_W     = 12,
  parameter int RESET_FIELD = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic               wr_lock,
  output logic [FIELD_W-1:0] field,
  output logic               locked,
  output logic               wr_taken
);

  // A write lands only while the register is still open
  assign wr_taken = wr_en && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field  <= FIELD_W'(RESET_FIELD);
      locked <= 1'b0;
    end else if (wr_taken) begin
      field  <= wr_field;
      locked <= wr_lock;
    end
  end

endmodule

// File: rtl/memwin_window.sv
module memwin_window
  import memwin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GRAN_W  = 20,
  localparam int FIELD_W = ADDR_W - GRAN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               probe_vld,
  input  logic [ADDR_W-1:0]  probe_addr,
  input  logic [FIELD_W-1:0] top_field,
  input  logic [FIELD_W-1:0] base_field,
  output logic               hit_vld,
  output logic               hit_mem,
  output logic               hit_seg
);

  logic [CMP_W-1:0] addr_ext, top_ext, base_ext;
  logic             mem_now, seg_now;

  // Granule-aligned limits: low GRAN_W bits are zero
  assign addr_ext = CMP_W'(probe_addr);
  assign top_ext  = CMP_W'({top_field,  {GRAN_W{1'b0}}});
  assign base_ext = CMP_W'({base_field, {GRAN_W{1'b0}}});

  assign mem_now = below_top(addr_ext, top_ext);
  assign seg_now = in_segment(addr_ext, base_ext, top_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vld <= 1'b0;
      hit_mem <= 1'b0;
      hit_seg <= 1'b0;
    end else begin
      hit_vld <= probe_vld;
      hit_mem <= probe_vld && mem_now;
      hit_seg <= probe_vld && seg_now;
    end
  end

endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_W   = 20,
  parameter int TOP_RST  = 1,
  parameter int BASE_RST = 0,
  localparam int FIELD_W = ADDR_W - GRAN_W,
  localparam int NREG    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_vld,
  output logic              hit_mem,
  output logic              hit_seg
);

  logic [FIELD_W-1:0] fld   [NREG];
  logic               lck   [NREG];
  logic               taken [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    memwin_lockreg #(
      .FIELD_W    (FIELD_W),
      .RESET_FIELD((g == int'(SEL_TOP)) ? TOP_RST : BASE_RST)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr && (cfg_sel == 1'(g))),
      .wr_field(cfg_wdata[ADDR_W-1:GRAN_W]),
      .wr_lock (cfg_wdata[0]),
      .field   (fld[g]),
      .locked  (lck[g]),
      .wr_taken(taken[g])
    );
  end

  // Named views for the checker
  logic [FIELD_W-1:0] top_field, base_field;
  logic               top_lock, base_lock, top_wr_taken, base_wr_taken;
  assign top_field     = fld[int'(SEL_TOP)];
  assign base_field    = fld[int'(SEL_BASE)];
  assign top_lock      = lck[int'(SEL_TOP)];
  assign base_lock     = lck[int'(SEL_BASE)];
  assign top_wr_taken  = taken[int'(SEL_TOP)];
  assign base_wr_taken = taken[int'(SEL_BASE)];

  // Reserved write bits carry no state
  logic unused_rsvd;
  assign unused_rsvd = ^cfg_wdata[GRAN_W-1:1];

  always_comb begin
    if (cfg_sel == SEL_BASE)
      cfg_rdata = {base_field, {(GRAN_W-1){1'b0}}, base_lock};
    else
      cfg_rdata = {top_field, {(GRAN_W-1){1'b0}}, top_lock};
  end

  memwin_window #(
    .ADDR_W(ADDR_W),
    .GRAN_W(GRAN_W)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_vld (addr_vld),
    .probe_addr(addr),
    .top_field (top_field),
    .base_field(base_field),
    .hit_vld   (hit_vld),
    .hit_mem   (hit_mem),
    .hit_seg   (hit_seg)
  );

endmodule

// File: rtl/memwin_decoder_chk.sv
module memwin_decoder_chk #(
  parameter int ADDR_W  = 32,
  parameter int GRAN_W  = 20,
  localparam int FIELD_W = ADDR_W - GRAN_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               addr_vld,
  input logic [ADDR_W-1:0]  addr,
  input logic               hit_vld,
  input logic               hit_mem,
  input logic               hit_seg,
  input logic [FIELD_W-1:0] top_field,
  input logic [FIELD_W-1:0] base_field,
  input logic               top_lock,
  input logic               base_lock,
  input logic               top_wr_taken,
  input logic               base_wr_taken
);

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> hit_vld);

  // R6
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_vld |-> (!hit_mem && !hit_seg));

  // R8
  seg_in_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_seg |-> hit_mem);

  // R7
  mem_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !hit_vld) |=>
      (hit_mem == ($past(addr) < {$past(top_field), {GRAN_W{1'b0}}})));

  // R4
  top_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_lock |=> ($stable(top_field) && !$past(top_wr_taken)));

  // R4
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_lock |=> ($stable(base_field) && !$past(base_wr_taken)));

  // R5
  top_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_lock |=> top_lock);

  // R5
  base_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_lock |=> base_lock);

  // R8
  empty_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && (base_field >= top_field)) |=> !hit_seg);

endmodule

bind memwin_decoder memwin_decoder_chk #(
  .ADDR_W(ADDR_W),
  .GRAN_W(GRAN_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_vld     (addr_vld),
  .addr         (addr),
  .hit_vld      (hit_vld),
  .hit_mem      (hit_mem),
  .hit_seg      (hit_seg),
  .top_field    (top_field),
  .base_field   (base_field),
  .top_lock     (top_lock),
  .base_lock    (base_lock),
  .top_wr_taken (top_wr_taken),
  .base_wr_taken(base_wr_taken)
);

// File: tb/memwin_decoder_tb.sv
`timescale 1ns/1ps
module memwin_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        addr_vld = 1'b0;
  logic [31:0] addr = '0;
  logic        hit_vld, hit_mem, hit_seg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  memwin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_vld(addr_vld),
    .addr(addr), .hit_vld(hit_vld), .hit_mem(hit_mem), .hit_seg(hit_seg)
  );

  // Behavioural reference: field values held in MB units
  longint m_top_mb, m_base_mb;
  bit     m_top_lk, m_base_lk;
  bit     e_vld, e_mem, e_seg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_top_mb <= 1; m_base_mb <= 0; m_top_lk <= 0; m_base_lk <= 0;
      e_vld <= 0; e_mem <= 0; e_seg <= 0;
    end else begin
      longint a, t, b;
      a = longint'(addr);
      t = m_top_mb * 1048576;
      b = m_base_mb * 1048576;
      e_vld <= addr_vld;
      e_mem <= addr_vld && (a < t);
      e_seg <= addr_vld && (b < t) && (a >= b) && (a < t);
      if (cfg_wr && !cfg_sel && !m_top_lk) begin
        m_top_mb <= longint'(cfg_wdata) / 1048576; m_top_lk <= cfg_wdata[0];
      end
      if (cfg_wr && cfg_sel && !m_base_lk) begin
        m_base_mb <= longint'(cfg_wdata) / 1048576; m_base_lk <= cfg_wdata[0];
      end
    end
  end

  function automatic longint model_rd(bit sel);
    return sel ? (m_base_mb * 1048576 + longint'(m_base_lk))
               : (m_top_mb * 1048576 + longint'(m_top_lk));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Every-cycle comparison, away from both edges
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R6 hit_vld", longint'(hit_vld), longint'(e_vld));
      chk("R7 hit_mem", longint'(hit_mem), longint'(e_mem));
      chk("R8 hit_seg", longint'(hit_seg), longint'(e_seg));
      chk("R2 rdata",   longint'(cfg_rdata), model_rd(cfg_sel));
    end
  end

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(string req, bit sel, logic [31:0] exp);
    cfg_sel = sel;
    #1;
    chk(req, longint'(cfg_rdata), longint'(exp));
  endtask

  task automatic probe(string req, logic [31:0] a, bit em, bit es);
    @(negedge clk);
    addr_vld = 1; addr = a;
    @(negedge clk);
    addr_vld = 0;
    chk({req, " mem"}, longint'(hit_mem), longint'(em));
    chk({req, " seg"}, longint'(hit_seg), longint'(es));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hit_vld", longint'(hit_vld), 0);
    chk("R1 hit_mem", longint'(hit_mem), 0);
    rd("R1 top reset", 1'b0, 32'h0010_0000);
    rd("R1 base reset", 1'b1, 32'h0000_0000);
    rst_n = 1;

    // R2 R3: reserved bits dropped, field loaded
    wr(1'b0, 32'hFFFF_FFFE);
    rd("R3 top write", 1'b0, 32'hFFF0_0000);
    rd("R2 reserved zero", 1'b0, 32'hFFF0_0000);
    // R9: select 1 is base; lock it
    wr(1'b1, 32'h4000_0001);
    rd("R9 base write", 1'b1, 32'h4000_0001);
    rd("R9 top untouched", 1'b0, 32'hFFF0_0000);
    wr(1'b1, 32'h1230_0000);
    rd("R4 base locked", 1'b1, 32'h4000_0001);

    // R7 R8: boundaries
    probe("R8 below base", 32'h3FFF_FFFF, 1, 0);
    probe("R8 at base", 32'h4000_0000, 1, 1);
    probe("R7 one under top", 32'hFFEF_FFFF, 1, 1);
    probe("R7 at top", 32'hFFF0_0000, 0, 0);
    probe("R7 max addr", 32'hFFFF_FFFF, 0, 0);

    // R8: base above top -> no segment
    wr(1'b0, 32'h2000_0000);
    probe("R8 base over top", 32'h4000_0000, 0, 0);
    probe("R8 empty seg", 32'h1000_0000, 1, 0);

    // R4 R5: lock top, try change and unlock
    wr(1'b0, 32'h2000_0001);
    wr(1'b0, 32'h3000_0000);
    rd("R4 top locked", 1'b0, 32'h2000_0001);
    wr(1'b0, 32'h2000_0000);
    rd("R5 lock sticky", 1'b0, 32'h2000_0001);

    // R5 R1: reset clears locks
    do_reset();
    rd("R5 top after reset", 1'b0, 32'h0010_0000);
    rd("R5 base after reset", 1'b1, 32'h0000_0000);
    wr(1'b1, 32'h0010_0000);
    rd("R5 base writable", 1'b1, 32'h0010_0000);
    probe("R8 base equals top", 32'h0000_0000, 1, 0);
    probe("R7 1MB top edge", 32'h0010_0000, 0, 0);

    // R6 R7 R8: random mix, compared every cycle
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cfg_wr    = ($urandom_range(0, 3) == 0);
      cfg_sel   = 1'($urandom_range(0, 1));
      cfg_wdata = $urandom() & 32'hFFF0_0000 | 32'(($urandom_range(0, 15) == 0));
      addr_vld  = 1'($urandom_range(0, 1));
      addr      = $urandom();
      if (i == 200) begin
        cfg_wr = 0;
        do_reset();
      end
    end
    @(negedge clk);
    cfg_wr = 0; addr_vld = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule